// File: doc/BRIEF.md
# External Bus Single-Beat Read Master

This block is the master side of an external memory bus that performs single-beat reads. The block is the only master on the bus, so no arbitration comes before a transfer. An internal requester presents an address, a size attribute and a chip-select decode result. The decode result says whether the address falls in a chip-select region, which region it is, and how many wait states that region needs. When the bus is idle the block accepts the request. In the next clock it pulses the active-low transfer-start strobe for one clock and drives the address and size onto the bus.

A cycle can be terminated from two sources. For a chip-select region, the block asserts the matching active-low chip select together with transfer start and acknowledges the cycle itself once the programmed number of wait states has elapsed. During such an access it ignores the external acknowledge. For any other access it waits for the slave to pull the external acknowledge or the external error line low. An error input always wins over an acknowledge. A bus-monitor counter ends with an error any cycle that no source terminates in time.

Read data is captured on the clock edge that ends the cycle. It is returned to the requester with a one-clock done pulse and an error flag.

Top module: `ebus_rd_master`

## Requirements
- R1: After reset, bus_ts_n is 1, every bit of bus_cs_n is 1, rsp_done is 0 and req_ready is 1.
- R2: A request is accepted on a rising edge where req_valid and req_ready are both 1. In the clock after that edge bus_ts_n is 0, and bus_addr and bus_size equal the request. bus_ts_n is 1 again in the following clock.
- R3: bus_addr and bus_size hold their values from the transfer-start clock until the clock in which rsp_done is 1.
- R4: For a chip-select request, bit req_cs_sel of bus_cs_n is 0 from the transfer-start clock through the last clock of the cycle, and all other bits are 1. All bits are 1 in the clock in which rsp_done is 1. A request with req_cs_hit=0 leaves every bit of bus_cs_n at 1.
- R5: For a chip-select request with wait count W (0 to 15), rsp_done is 1 exactly W+1 clocks after the transfer-start clock, with rsp_err=0 and rsp_data equal to bus_data_in in the clock before. bus_ta_n held at 0 throughout has no effect on that timing.
- R6: For a request that is not chip-select, a 0 on bus_ta_n sampled on a rising edge ends the cycle. rsp_done is 1 in the next clock, with rsp_err=0 and rsp_data equal to bus_data_in sampled on that edge.
- R7: A 0 on bus_tea_n sampled on a rising edge ends the cycle with rsp_err=1 and rsp_data=0, even if bus_ta_n is 0 on the same edge.
- R8: During a chip-select access, bus_tea_n=0 ends the cycle with an error before the wait count expires.
- R9: If no termination arrives, rsp_done is 1 with rsp_err=1 exactly 255 clocks after the transfer-start clock.
- R10: rsp_done lasts exactly one clock. req_ready is 0 from acceptance until the done clock, and req_valid presented while req_ready is 0 starts no transfer and does not change bus_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Bus idle, request can be accepted |
| req_addr | input | AW | Request address |
| req_size | input | SW | Request size attribute |
| req_cs_hit | input | 1 | Address falls in a chip-select region |
| req_cs_sel | input | CSW | Index of the chip-select region |
| req_wait | input | WSW | Wait states for a chip-select region |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_data | output | DW | Read data, zero on error |
| rsp_err | output | 1 | Cycle ended with an error |
| bus_addr | output | AW | Bus address |
| bus_size | output | SW | Bus size attribute |
| bus_ts_n | output | 1 | Transfer-start strobe, active low |
| bus_cs_n | output | NCS | Chip selects, active low |
| bus_data_in | input | DW | Read data from the bus |
| bus_ta_n | input | 1 | External acknowledge, active low |
| bus_tea_n | input | 1 | External error acknowledge, active low |

## Verification
The bench measures chip-select latency at wait counts of 0, 3 and 15, with the external acknowledge held low the whole time. An off-by-one counter shows up as a shifted done pulse, and a design that obeys the external acknowledge would finish at once. It drives the error and acknowledge lines low on the same edge to catch a design that reports good data there. It also raises an error in the middle of a chip-select wait. It leaves a cycle unanswered to check that the bus monitor fires on exactly clock 255 and not one early or late. Finally, it presents a request while the bus is busy, which a design with a loose ready would accept and use to overwrite the address in flight.

// File: rtl/ebus_rd_master.sv
`timescale 1ns/1ps
module ebus_rd_master #(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int SW  = 2,
  parameter int NCS = 4,
  parameter int WSW = 4,
  parameter int TMO = 255,
  localparam int CSW = (NCS > 1) ? $clog2(NCS) : 1,
  localparam int TW  = $clog2(TMO + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [AW-1:0]  req_addr,
  input  logic [SW-1:0]  req_size,
  input  logic           req_cs_hit,
  input  logic [CSW-1:0] req_cs_sel,
  input  logic [WSW-1:0] req_wait,
  output logic           rsp_done,
  output logic [DW-1:0]  rsp_data,
  output logic           rsp_err,
  output logic [AW-1:0]  bus_addr,
  output logic [SW-1:0]  bus_size,
  output logic           bus_ts_n,
  output logic [NCS-1:0] bus_cs_n,
  input  logic [DW-1:0]  bus_data_in,
  input  logic           bus_ta_n,
  input  logic           bus_tea_n
);

  logic           busy, ts_q, cs_mode;
  logic [TW-1:0]  cnt;
  logic [WSW-1:0] wait_q;
  logic [NCS-1:0] cs_q;
  logic [AW-1:0]  addr_q;
  logic [SW-1:0]  size_q;

  wire start  = req_valid && !busy;
  wire int_ta = busy && cs_mode && (cnt == TW'(wait_q));
  wire ext_ta = busy && !cs_mode && !bus_ta_n;
  wire err_ta = busy && !bus_tea_n;
  wire tmo    = busy && (cnt == TW'(TMO - 1));
  wire term   = int_ta || ext_ta || err_ta || tmo;
  wire fail   = err_ta || (tmo && !int_ta && !ext_ta);

  assign req_ready = !busy;
  assign bus_ts_n  = !ts_q;
  assign bus_cs_n  = ~cs_q;
  assign bus_addr  = addr_q;
  assign bus_size  = size_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      ts_q     <= 1'b0;
      cs_mode  <= 1'b0;
      cnt      <= '0;
      wait_q   <= '0;
      cs_q     <= '0;
      addr_q   <= '0;
      size_q   <= '0;
      rsp_done <= 1'b0;
      rsp_data <= '0;
      rsp_err  <= 1'b0;
    end else begin
      ts_q     <= start;
      rsp_done <= 1'b0;
      if (start) begin
        busy    <= 1'b1;
        cnt     <= '0;
        addr_q  <= req_addr;
        size_q  <= req_size;
        cs_mode <= req_cs_hit;
        wait_q  <= req_wait;
        cs_q    <= req_cs_hit ? (NCS'(1) << req_cs_sel) : '0;
      end else if (term) begin
        busy     <= 1'b0;
        cs_q     <= '0;
        rsp_done <= 1'b1;
        rsp_err  <= fail;
        rsp_data <= fail ? '0 : bus_data_in;
      end else if (busy) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R2
  ts_one_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ts_n |=> bus_ts_n);

  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && $past(!req_ready)) |-> ($stable(bus_addr) && $stable(bus_size)));

  // R4
  cs_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~bus_cs_n));

  // R4
  cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (&bus_cs_n));

  // R7
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && rsp_err) |-> (rsp_data == '0));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> req_ready);

endmodule

// File: tb/ebus_rd_master_bench.sv
`timescale 1ns/1ps
module ebus_rd_master_bench;
  localparam int AW = 32, DW = 32, SW = 2, NCS = 4, WSW = 4;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_cs_hit = 0;
  logic [AW-1:0] req_addr = '0;
  logic [SW-1:0] req_size = '0;
  logic [1:0] req_cs_sel = '0;
  logic [WSW-1:0] req_wait = '0;
  logic [DW-1:0] bus_data_in = '0;
  logic bus_ta_n = 1, bus_tea_n = 1;
  logic req_ready, rsp_done, rsp_err, bus_ts_n;
  logic [DW-1:0] rsp_data;
  logic [AW-1:0] bus_addr;
  logic [SW-1:0] bus_size;
  logic [NCS-1:0] bus_cs_n;

  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  ebus_rd_master u_ebus_rd_master (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .req_cs_hit(req_cs_hit),
    .req_cs_sel(req_cs_sel), .req_wait(req_wait), .rsp_done(rsp_done),
    .rsp_data(rsp_data), .rsp_err(rsp_err), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_ts_n(bus_ts_n), .bus_cs_n(bus_cs_n),
    .bus_data_in(bus_data_in), .bus_ta_n(bus_ta_n), .bus_tea_n(bus_tea_n));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic start_rd(input logic [AW-1:0] a, input logic [SW-1:0] sz,
                          input bit cs, input logic [1:0] sel, input logic [WSW-1:0] w);
    logic [NCS-1:0] exp_cs;
    exp_cs = cs ? ~(NCS'(1) << sel) : '1;
    @(negedge clk);
    chk(req_ready == 1, "R10", "ready when idle", req_ready, 1);
    req_valid = 1; req_addr = a; req_size = sz; req_cs_hit = cs; req_cs_sel = sel; req_wait = w;
    @(negedge clk);
    req_valid = 0; req_addr = ~a;
    chk(bus_ts_n == 0, "R2", "ts low", bus_ts_n, 0);
    chk(bus_addr == a && bus_size == sz, "R2", "addr on bus", bus_addr, a);
    chk(bus_cs_n == exp_cs, "R4", "cs at start", bus_cs_n, exp_cs);
  endtask

  task automatic t_reset;
    chk(bus_ts_n == 1, "R1", "ts reset", bus_ts_n, 1);
    chk(bus_cs_n == '1, "R1", "cs reset", bus_cs_n, '1);
    chk(rsp_done == 0, "R1", "done reset", rsp_done, 0);
    chk(req_ready == 1, "R1", "ready reset", req_ready, 1);
  endtask

  task automatic t_cs(input logic [AW-1:0] a, input logic [1:0] sel,
                      input logic [WSW-1:0] w, input logic [DW-1:0] d);
    int k;
    bus_data_in = d; bus_ta_n = 0;
    start_rd(a, 2'd2, 1, sel, w);
    k = 0;
    while (!rsp_done && k < 40) begin
      chk(bus_cs_n[sel] == 0, "R4", "cs held", bus_cs_n, ~(NCS'(1) << sel));
      chk(bus_addr == a, "R3", "addr stable", bus_addr, a);
      if (k == 1) chk(bus_ts_n == 1, "R2", "ts one clock", bus_ts_n, 1);
      @(negedge clk); k++;
    end
    bus_ta_n = 1;
    chk(k == int'(w) + 1, "R5", "cs latency", k, int'(w) + 1);
    chk(rsp_data == d && rsp_err == 0, "R5", "cs data", rsp_data, d);
    chk(bus_cs_n == '1, "R4", "cs released", bus_cs_n, '1);
    @(negedge clk);
    chk(rsp_done == 0, "R10", "done one clock", rsp_done, 0);
  endtask

  task automatic t_ext(input int n, input bit ta, input bit tea, input logic [DW-1:0] d);
    logic [DW-1:0] exp_d;
    exp_d = tea ? '0 : d;
    start_rd(32'h8000_0100 + n, 2'd1, 0, 0, 0);
    for (int i = 0; i < n; i++) begin
      chk(rsp_done == 0, "R6", "no early done", rsp_done, 0);
      chk(bus_cs_n == '1, "R4", "no cs", bus_cs_n, '1);
      @(negedge clk);
    end
    bus_ta_n = !ta; bus_tea_n = !tea; bus_data_in = d;
    @(negedge clk);
    bus_ta_n = 1; bus_tea_n = 1; bus_data_in = ~d;
    chk(rsp_done == 1, tea ? "R7" : "R6", "done", rsp_done, 1);
    chk(rsp_err == tea, tea ? "R7" : "R6", "err flag", rsp_err, tea);
    chk(rsp_data == exp_d, tea ? "R7" : "R6", "data", rsp_data, exp_d);
    @(negedge clk);
    chk(rsp_done == 0, "R10", "done one clock", rsp_done, 0);
  endtask

  task automatic t_cs_tea;
    int k;
    start_rd(32'h0000_4000, 2'd2, 1, 2'd3, 4'd10);
    @(negedge clk); @(negedge clk);
    bus_tea_n = 0;
    @(negedge clk);
    bus_tea_n = 1;
    chk(rsp_done == 1 && rsp_err == 1, "R8", "tea ends cs cycle", {rsp_done, rsp_err}, 2'b11);
    chk(bus_cs_n == '1, "R8", "cs released", bus_cs_n, '1);
    k = 0;
    @(negedge clk);
  endtask

  task automatic t_tmo;
    int k;
    start_rd(32'hDEAD_0000, 2'd0, 0, 0, 0);
    k = 0;
    while (!rsp_done && k < 400) begin @(negedge clk); k++; end
    chk(k == 255, "R9", "monitor latency", k, 255);
    chk(rsp_err == 1 && rsp_data == 0, "R9", "monitor error", rsp_err, 1);
    @(negedge clk);
  endtask

  task automatic t_busy;
    start_rd(32'h1234_5678, 2'd3, 0, 0, 0);
    req_valid = 1; req_addr = 32'hFFFF_0000;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(req_ready == 0, "R10", "busy not ready", req_ready, 0);
      chk(bus_addr == 32'h1234_5678, "R10", "addr kept", bus_addr, 32'h1234_5678);
      chk(bus_ts_n == 1, "R10", "no restart", bus_ts_n, 1);
    end
    req_valid = 0;
    bus_ta_n = 0; bus_data_in = 32'h55AA_55AA;
    @(negedge clk);
    bus_ta_n = 1;
    chk(rsp_done == 1 && rsp_data == 32'h55AA_55AA, "R6", "busy read done", rsp_data, 32'h55AA_55AA);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(bus_ts_n == 1 && req_ready == 1, "R10", "no late start", bus_ts_n, 1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_cs(32'h0000_1000, 2'd1, 4'd0, 32'hA5A5_0001);
    t_cs(32'h0000_2000, 2'd2, 4'd3, 32'hA5A5_0003);
    t_cs(32'h0000_3000, 2'd0, 4'd15, 32'hA5A5_000F);
    t_ext(0, 1, 0, 32'h1111_2222);
    t_ext(5, 1, 0, 32'h3333_4444);
    t_ext(2, 0, 1, 32'h5555_6666);
    t_ext(3, 1, 1, 32'h7777_8888);
    t_cs_tea();
    t_tmo();
    t_busy();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20ns * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule